// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block sits between a UART's receive path, its receive FIFO and its transmitter and handles in-band flow control. Every received byte is compared with two programmable flow codes: the pause code stops the local transmitter's data, and the resume code lets it run again. The detection raises a one-cycle pulse for each code, and both codes can be removed from the byte stream that goes on to the FIFO.

In the other direction the block watches the receive-FIFO fill level. When the level climbs above an upper threshold it queues a pause code for the far end. When it drops below a lower threshold it queues a resume code. Software can queue either code directly with a one-shot command. Each command stays visible as pending until the transmitter takes the character. Two force inputs override the received pause state. A still-send option lets queued flow codes go out while data transmission is paused. Flow codes reach the transmitter through a request/grant handshake. The character is latched when the request goes up and is held until the grant.

Top module: `xflow_ctrl`

## Requirements
- R1: After reset, tx_en_o is 1, fc_req_o is 0, both interrupt pulses are 0, and neither pending flag is set.
- R2: With cfg_en_i set and no force, a received byte equal to cfg_xoff_char_i clears tx_en_o from the next cycle, and a byte equal to cfg_xon_char_i sets it again. If both codes are programmed equal, the byte counts as a pause code.
- R3: A received pause code or resume code (cfg_en_i set) gives a single-cycle pulse on off_irq_o or on_irq_o, respectively, in the cycle after the byte is presented. The two pulses are never high together.
- R4: With cfg_en_i and cfg_del_i set, a received flow code leaves rx_valid_o low. Every other byte passes, with rx_valid_o equal to rx_valid_i and rx_data_o equal to rx_data_i in the same cycle.
- R5: cfg_force_off_i drives tx_en_o low at once. Otherwise cfg_force_on_i drives it high at once. The force inputs act whatever the received pause state is, and cfg_force_off_i wins when both are set.
- R6: With cfg_en_i set, a rise of rx_level_i from not-above to above cfg_off_thr_i queues exactly one pause code (pend_xoff_o high from the next cycle). The level staying above the threshold queues nothing more.
- R7: With cfg_en_i set, a fall of rx_level_i to below cfg_on_thr_i queues exactly one resume code (pend_xon_o high from the next cycle), once per crossing. At reset the level counts as already below.
- R8: A one-cycle pulse on cmd_xon_i or cmd_xoff_i sets the matching pending flag from the next cycle. The flag clears on its own in the cycle after fc_gnt_i accepts that character.
- R9: When both codes are pending, the pause code is issued first and the resume code follows after its grant. fc_char_o shows the code that was latched when the request was issued.
- R10: A new request is issued only while tx_en_o is high or cfg_still_send_i is set. Once fc_req_o is high, it stays high with fc_char_o unchanged until fc_gnt_i.
- R11: With cfg_en_i clear, received bytes all pass unchanged. They cause no pause and no pulse, the pause state returns to running, and level crossings queue nothing. Software commands still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Flow-control enable |
| cfg_xon_char_i | input | CHAR_W | Resume code (typically 0x11) |
| cfg_xoff_char_i | input | CHAR_W | Pause code (typically 0x13) |
| cfg_del_i | input | 1 | Remove received flow codes from the stream |
| cfg_still_send_i | input | 1 | Allow flow codes out while data is paused |
| cfg_force_on_i | input | 1 | Force data transmission on |
| cfg_force_off_i | input | 1 | Force data transmission off |
| cfg_on_thr_i | input | LVL_W | Level below which a resume code is queued |
| cfg_off_thr_i | input | LVL_W | Level above which a pause code is queued |
| cmd_xon_i | input | 1 | One-shot: queue a resume code |
| cmd_xoff_i | input | 1 | One-shot: queue a pause code |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | CHAR_W | Received byte |
| rx_valid_o | output | 1 | Byte strobe toward the receive FIFO |
| rx_data_o | output | CHAR_W | Byte toward the receive FIFO |
| rx_level_i | input | LVL_W | Receive-FIFO fill level |
| tx_en_o | output | 1 | Data transmission allowed |
| fc_req_o | output | 1 | Flow-code request to the transmitter |
| fc_char_o | output | CHAR_W | Flow code to send |
| fc_gnt_i | input | 1 | Transmitter accepts the flow code |
| pend_xon_o | output | 1 | Resume code queued, not yet granted |
| pend_xoff_o | output | 1 | Pause code queued, not yet granted |
| on_irq_o | output | 1 | Resume code received pulse |
| off_irq_o | output | 1 | Pause code received pulse |

## Verification
The bench builds the block with CHAR_W = 8 and LVL_W = 5, so the FIFO level runs over 0 to 31. That range puts both threshold crossings and the reset case of the lower threshold within a few cycles. A behavioural model tracks the pause state, the crossing history and the request queue, and the bench compares it with every output on each clock. Directed sequences cover several cases: grants held back while commands pile up, both commands in one cycle, flow codes blocked and then let through by the still-send option, equal pause and resume codes, and traffic while the feature is disabled.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
  localparam logic [7:0] XON_DEF  = 8'h11;
  localparam logic [7:0] XOFF_DEF = 8'h13;
  localparam int unsigned NUM_CMP = 2;
  localparam int unsigned CMP_ON  = 0;
  localparam int unsigned CMP_OFF = 1;
  typedef enum logic { ARB_IDLE = 1'b0, ARB_BUSY = 1'b1 } arb_st_e;
endpackage

// File: rtl/xfc_rx_watch.sv
module xfc_rx_watch #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              del_i,
  input  logic [CHAR_W-1:0] xon_i,
  input  logic [CHAR_W-1:0] xoff_i,
  input  logic              valid_i,
  input  logic [CHAR_W-1:0] data_i,
  output logic              valid_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              paused_o,
  output logic              on_irq_o,
  output logic              off_irq_o
);
  logic hit_off, hit_on;

  // pause code takes precedence when both codes are equal
  always_comb begin
    hit_off = en_i & valid_i & (data_i == xoff_i);
    hit_on  = en_i & valid_i & (data_i == xon_i) & ~hit_off;
    valid_o = valid_i & ~(del_i & (hit_on | hit_off));
    data_o  = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paused_o  <= 1'b0;
      on_irq_o  <= 1'b0;
      off_irq_o <= 1'b0;
    end else begin
      on_irq_o  <= hit_on;
      off_irq_o <= hit_off;
      if (!en_i)        paused_o <= 1'b0;
      else if (hit_off) paused_o <= 1'b1;
      else if (hit_on)  paused_o <= 1'b0;
    end
  end
endmodule

// File: rtl/xfc_level_watch.sv
module xfc_level_watch
  import xfc_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] on_thr_i,
  input  logic [LVL_W-1:0] off_thr_i,
  output logic             auto_on_o,
  output logic             auto_off_o
);
  logic [NUM_CMP-1:0] cond, prev, fire;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    // lower comparator starts as "already below" so reset queues nothing
    localparam logic PREV_RST = (g == CMP_ON) ? 1'b1 : 1'b0;
    if (g == CMP_ON) begin : g_below
      assign cond[g] = level_i < on_thr_i;
    end else begin : g_above
      assign cond[g] = level_i > off_thr_i;
    end
    assign fire[g] = en_i & cond[g] & ~prev[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev[g] <= PREV_RST;
      else         prev[g] <= cond[g];
    end
  end

  assign auto_on_o  = fire[CMP_ON];
  assign auto_off_o = fire[CMP_OFF];
endmodule

// File: rtl/xfc_tx_arb.sv
module xfc_tx_arb
  import xfc_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_on_i,
  input  logic              set_off_i,
  input  logic              gate_i,
  input  logic [CHAR_W-1:0] xon_i,
  input  logic [CHAR_W-1:0] xoff_i,
  input  logic              gnt_i,
  output logic              req_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              pend_on_o,
  output logic              pend_off_o
);
  arb_st_e st_q;
  logic    sel_off_q, done_on, done_off;
  logic [CHAR_W-1:0] char_q;

  assign done_off = (st_q == ARB_BUSY) & gnt_i &  sel_off_q;
  assign done_on  = (st_q == ARB_BUSY) & gnt_i & ~sel_off_q;

  // a new set in the grant cycle schedules one more character
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_on_o  <= 1'b0;
      pend_off_o <= 1'b0;
    end else begin
      pend_on_o  <= set_on_i  | (pend_on_o  & ~done_on);
      pend_off_o <= set_off_i | (pend_off_o & ~done_off);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ARB_IDLE;
      sel_off_q <= 1'b0;
      char_q    <= '0;
    end else begin
      unique case (st_q)
        ARB_IDLE: if ((pend_on_o | pend_off_o) & gate_i) begin
          st_q      <= ARB_BUSY;
          sel_off_q <= pend_off_o;
          char_q    <= pend_off_o ? xoff_i : xon_i;
        end
        ARB_BUSY: if (gnt_i) st_q <= ARB_IDLE;
        default:  st_q <= ARB_IDLE;
      endcase
    end
  end

  assign req_o  = (st_q == ARB_BUSY);
  assign char_o = char_q;
endmodule

// File: rtl/xflow_ctrl.sv
module xflow_ctrl
  import xfc_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned LVL_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic [CHAR_W-1:0] cfg_xon_char_i,
  input  logic [CHAR_W-1:0] cfg_xoff_char_i,
  input  logic              cfg_del_i,
  input  logic              cfg_still_send_i,
  input  logic              cfg_force_on_i,
  input  logic              cfg_force_off_i,
  input  logic [LVL_W-1:0]  cfg_on_thr_i,
  input  logic [LVL_W-1:0]  cfg_off_thr_i,
  input  logic              cmd_xon_i,
  input  logic              cmd_xoff_i,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  output logic              rx_valid_o,
  output logic [CHAR_W-1:0] rx_data_o,
  input  logic [LVL_W-1:0]  rx_level_i,
  output logic              tx_en_o,
  output logic              fc_req_o,
  output logic [CHAR_W-1:0] fc_char_o,
  input  logic              fc_gnt_i,
  output logic              pend_xon_o,
  output logic              pend_xoff_o,
  output logic              on_irq_o,
  output logic              off_irq_o
);
  logic paused, auto_on, auto_off;

  xfc_rx_watch #(.CHAR_W(CHAR_W)) u_rx (
    .clk_i, .rst_ni,
    .en_i     (cfg_en_i),
    .del_i    (cfg_del_i),
    .xon_i    (cfg_xon_char_i),
    .xoff_i   (cfg_xoff_char_i),
    .valid_i  (rx_valid_i),
    .data_i   (rx_data_i),
    .valid_o  (rx_valid_o),
    .data_o   (rx_data_o),
    .paused_o (paused),
    .on_irq_o (on_irq_o),
    .off_irq_o(off_irq_o)
  );

  xfc_level_watch #(.LVL_W(LVL_W)) u_lvl (
    .clk_i, .rst_ni,
    .en_i      (cfg_en_i),
    .level_i   (rx_level_i),
    .on_thr_i  (cfg_on_thr_i),
    .off_thr_i (cfg_off_thr_i),
    .auto_on_o (auto_on),
    .auto_off_o(auto_off)
  );

  always_comb begin
    if (cfg_force_off_i)     tx_en_o = 1'b0;
    else if (cfg_force_on_i) tx_en_o = 1'b1;
    else                     tx_en_o = ~paused;
  end

  xfc_tx_arb #(.CHAR_W(CHAR_W)) u_arb (
    .clk_i, .rst_ni,
    .set_on_i  (cmd_xon_i  | auto_on),
    .set_off_i (cmd_xoff_i | auto_off),
    .gate_i    (tx_en_o | cfg_still_send_i),
    .xon_i     (cfg_xon_char_i),
    .xoff_i    (cfg_xoff_char_i),
    .gnt_i     (fc_gnt_i),
    .req_o     (fc_req_o),
    .char_o    (fc_char_o),
    .pend_on_o (pend_xon_o),
    .pend_off_o(pend_xoff_o)
  );
endmodule

// File: rtl/xflow_ctrl_chk.sv
module xflow_ctrl_chk #(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned LVL_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_en_i,
  input logic [CHAR_W-1:0] cfg_xon_char_i,
  input logic [CHAR_W-1:0] cfg_xoff_char_i,
  input logic              cfg_del_i,
  input logic              cfg_force_on_i,
  input logic              cfg_force_off_i,
  input logic              rx_valid_i,
  input logic [CHAR_W-1:0] rx_data_i,
  input logic              rx_valid_o,
  input logic              tx_en_o,
  input logic              fc_req_o,
  input logic [CHAR_W-1:0] fc_char_o,
  input logic              fc_gnt_i,
  input logic              pend_xoff_o,
  input logic              on_irq_o,
  input logic              off_irq_o
);
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_req_o && !fc_gnt_i |=> fc_req_o && $stable(fc_char_o));
  // R3
  irq_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({on_irq_o, off_irq_o}));
  // R2
  pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_force_on_i && $past(cfg_en_i && rx_valid_i && rx_data_i == cfg_xoff_char_i)
      |-> !tx_en_o);
  // R4
  del_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i && cfg_del_i && rx_valid_i &&
      (rx_data_i == cfg_xon_char_i || rx_data_i == cfg_xoff_char_i) |-> !rx_valid_o);
  // R8
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_xoff_o) |-> $past(fc_req_o && fc_gnt_i));
  // R5
  force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_force_off_i |-> !tx_en_o);
endmodule

bind xflow_ctrl xflow_ctrl_chk #(.CHAR_W(CHAR_W), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/xflow_ctrl_test.sv
module xflow_ctrl_test;
  import xfc_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int LW = 5;

  logic clk = 0, rst_n = 0;
  logic en = 0, del = 0, still = 0, fon = 0, foff = 0, cxon = 0, cxoff = 0;
  logic [CW-1:0] xon_c = XON_DEF, xoff_c = XOFF_DEF, rdat = 0;
  logic rval = 0, gnt = 0;
  logic [LW-1:0] on_thr = 0, off_thr = 12, lvl = 0;
  logic rval_o, tx_en, req, pon, poff, oirq, firq;
  logic [CW-1:0] rdat_o, fchar;

  int errors = 0, checks = 0;

  xflow_ctrl #(.CHAR_W(CW), .LVL_W(LW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_en_i(en), .cfg_xon_char_i(xon_c),
    .cfg_xoff_char_i(xoff_c), .cfg_del_i(del), .cfg_still_send_i(still),
    .cfg_force_on_i(fon), .cfg_force_off_i(foff), .cfg_on_thr_i(on_thr),
    .cfg_off_thr_i(off_thr), .cmd_xon_i(cxon), .cmd_xoff_i(cxoff),
    .rx_valid_i(rval), .rx_data_i(rdat), .rx_valid_o(rval_o), .rx_data_o(rdat_o),
    .rx_level_i(lvl), .tx_en_o(tx_en), .fc_req_o(req), .fc_char_o(fchar),
    .fc_gnt_i(gnt), .pend_xon_o(pon), .pend_xoff_o(poff),
    .on_irq_o(oirq), .off_irq_o(firq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit m_paused = 0, m_oirq = 0, m_firq = 0, m_above = 0, m_below = 1;
  bit m_pon = 0, m_poff = 0, m_busy = 0, m_sel_off = 0;
  int m_char = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  function automatic bit m_txen();
    if (foff) return 0;
    if (fon) return 1;
    return !m_paused;
  endfunction

  task automatic tick();
    bit hit_off, hit_on, a_off, a_on, grant, np_on, np_off;
    #1;
    chk(tx_en == m_txen(), "R2/R5 tx_en_o", tx_en, m_txen());
    hit_off = en && rval && rdat == xoff_c;
    hit_on  = en && rval && rdat == xon_c && !hit_off;
    chk(rval_o == (rval && !(del && (hit_on || hit_off))), "R4 rx_valid_o", rval_o,
        rval && !(del && (hit_on || hit_off)));
    chk(rdat_o == rdat, "R4 rx_data_o", rdat_o, rdat);
    chk(oirq == m_oirq && firq == m_firq, "R3 irq", {oirq, firq}, {m_oirq, m_firq});
    chk(req == m_busy, "R10 fc_req_o", req, m_busy);
    if (m_busy) chk(fchar == m_char, "R9 fc_char_o", fchar, m_char);
    chk(pon == m_pon && poff == m_poff, "R8 pending", {pon, poff}, {m_pon, m_poff});
    // next state
    a_off = en && (lvl > off_thr) && !m_above;
    a_on  = en && (lvl < on_thr) && !m_below;
    grant = m_busy && gnt;
    np_off = cxoff || a_off || (m_poff && !(grant && m_sel_off));
    np_on  = cxon  || a_on  || (m_pon  && !(grant && !m_sel_off));
    if (m_busy) m_busy = !gnt;
    else if ((m_pon || m_poff) && (m_txen() || still)) begin
      m_busy = 1; m_sel_off = m_poff; m_char = m_poff ? xoff_c : xon_c;
    end
    m_pon = np_on; m_poff = np_off;
    m_above = lvl > off_thr; m_below = lvl < on_thr;
    m_oirq = hit_on; m_firq = hit_off;
    if (!en) m_paused = 0;
    else if (hit_off) m_paused = 1;
    else if (hit_on) m_paused = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rx_byte(input logic [CW-1:0] b);
    rval = 1; rdat = b; tick(); rval = 0; rdat = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk(tx_en == 1 && req == 0 && pon == 0 && poff == 0 && oirq == 0 && firq == 0,
        "R1 reset", {tx_en, req, pon, poff, oirq, firq}, 6'b100000);
    rst_n = 1;
    idle(2);

    // R11 disabled: codes pass, no pause, no auto request
    rx_byte(XOFF_DEF);
    chk(tx_en == 1, "R11 no pause when disabled", tx_en, 1);
    lvl = 20; idle(2);
    chk(poff == 0, "R11 no auto request when disabled", poff, 0);
    lvl = 0; idle(1);

    // R2/R3 pause and resume
    en = 1;
    rx_byte(XOFF_DEF);
    chk(tx_en == 0, "R2 pause on received code", tx_en, 0);
    chk(firq == 1, "R3 pause pulse", firq, 1);
    idle(1);
    chk(firq == 0, "R3 pulse one cycle", firq, 0);
    rx_byte(8'h41);
    chk(tx_en == 0, "R2 ordinary byte keeps pause", tx_en, 0);
    rx_byte(XON_DEF);
    chk(tx_en == 1 && oirq == 1, "R2 resume", {tx_en, oirq}, 2'b11);

    // R4 delete
    del = 1;
    rval = 1; rdat = XON_DEF; #1;
    chk(rval_o == 0, "R4 resume code dropped", rval_o, 0);
    tick();
    rdat = 8'h55; #1;
    chk(rval_o == 1 && rdat_o == 8'h55, "R4 ordinary byte passes", rval_o, 1);
    tick(); rval = 0; del = 0;

    // R5 forces
    rx_byte(XOFF_DEF);
    fon = 1; #1;
    chk(tx_en == 1, "R5 force on overrides pause", tx_en, 1);
    foff = 1; #1;
    chk(tx_en == 0, "R5 force off wins", tx_en, 0);
    tick(); fon = 0; foff = 0;
    rx_byte(XON_DEF);

    // R8 one-shot command held until grant
    cxon = 1; tick(); cxon = 0;
    chk(pon == 1, "R8 pending set", pon, 1);
    idle(3);
    chk(req == 1 && fchar == XON_DEF, "R8 request waits for grant", fchar, XON_DEF);
    gnt = 1; tick(); gnt = 0;
    chk(pon == 0 && req == 0, "R8 cleared after grant", {pon, req}, 0);

    // R9 both pending: pause code first
    cxon = 1; cxoff = 1; tick(); cxon = 0; cxoff = 0;
    tick();
    chk(fchar == XOFF_DEF && req, "R9 pause code first", fchar, XOFF_DEF);
    gnt = 1; tick(); gnt = 0;
    tick();
    chk(fchar == XON_DEF && req, "R9 resume follows", fchar, XON_DEF);
    gnt = 1; tick(); gnt = 0;

    // R10 gating while paused
    rx_byte(XOFF_DEF);
    cxoff = 1; tick(); cxoff = 0;
    idle(3);
    chk(req == 0 && poff == 1, "R10 blocked while paused", req, 0);
    still = 1; idle(2);
    chk(req == 1, "R10 still-send lets code out", req, 1);
    still = 0; idle(2);
    chk(req == 1 && fchar == XOFF_DEF, "R10 held until grant", req, 1);
    gnt = 1; tick(); gnt = 0;
    rx_byte(XON_DEF);

    // R2 equal codes: treated as pause
    xon_c = 8'h7e; xoff_c = 8'h7e;
    rx_byte(8'h7e);
    chk(tx_en == 0 && firq == 1 && oirq == 0, "R2 equal codes pause", {tx_en, firq, oirq}, 3'b010);
    xon_c = XON_DEF; xoff_c = XOFF_DEF;
    rx_byte(XON_DEF);

    // R6 upper crossing, once per crossing
    off_thr = 20; lvl = 20; tick();
    chk(poff == 0, "R6 equal level is not above", poff, 0);
    lvl = 21; tick();
    chk(poff == 1, "R6 crossing queues pause code", poff, 1);
    tick(); gnt = 1; tick(); gnt = 0;
    idle(4);
    chk(poff == 0 && req == 0, "R6 no repeat while above", {poff, req}, 0);
    lvl = 31; idle(2);
    chk(poff == 0, "R6 still no repeat at full scale", poff, 0);

    // R7 lower crossing
    on_thr = 5; lvl = 5; tick();
    chk(pon == 0, "R7 equal level is not below", pon, 0);
    lvl = 3; tick();
    chk(pon == 1, "R7 crossing queues resume code", pon, 1);
    tick(); gnt = 1; tick(); gnt = 0;
    idle(3);
    chk(pon == 0, "R7 no repeat while below", pon, 0);
    lvl = 8; idle(1); lvl = 2; tick();
    chk(pon == 1, "R7 second crossing queues again", pon, 1);
    tick(); gnt = 1; tick(); gnt = 0;

    // R11 disable clears pause, commands still work
    rx_byte(XOFF_DEF);
    en = 0; tick();
    chk(tx_en == 1, "R11 disable returns to running", tx_en, 1);
    cxoff = 1; tick(); cxoff = 0;
    chk(poff == 1, "R11 command works while disabled", poff, 1);
    tick(); gnt = 1; tick(); gnt = 0;
    idle(3);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule